// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block turns one loaded parameter set into the ordered list of array requests that a DMA transfer engine consumes. A transfer is shaped as a number of frames, each made of a number of arrays, each array being a run of contiguous bytes. For every array the sequencer offers a source address, a destination address and a byte length on a valid/ready handshake. It computes the next addresses from separate signed strides for source and destination: one stride between arrays and one between frames.

Progress is paced by sync events. In single-array mode one event releases exactly one array. In whole-frame mode one event releases all arrays of the current frame back to back. The two modes measure the frame stride from different bases. In single-array mode it is added to the start of the last array moved. In whole-frame mode it is added to the start of the current frame. For a contiguous 12-byte block cut as 2-byte arrays, 2 per frame and 3 frames, the array stride is 2 in both modes, while the frame stride is 2 in single-array mode and 4 in whole-frame mode.

A one-cycle pulse follows each event's work that does not end the transfer. A different one-cycle pulse follows the final array. The remaining frame and array counts and the current addresses are visible at all times.

Top module: `dma3d_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `inter_done` and `final_done` are all 0.
- R2: A `start` pulse while idle, with non-zero array and frame counts, loads the parameter set. One cycle later `busy` is 1, `cur_src`/`cur_dst` equal the configured start addresses and `cur_ccnt` equals the frame count. A `start` with a zero array or frame count is ignored. A `start` while busy is ignored.
- R3: With `cfg_frame_mode` = 0 (single-array mode), each event issues one request of length `cfg_acnt`. Within a frame, each array starts at the previous array's start plus the sign-extended array stride.
- R4: In single-array mode, the first array of the next frame starts at the last array's start plus the sign-extended frame stride. Every frame after the first has `cfg_bcnt_rld` arrays.
- R5: With `cfg_frame_mode` = 1 (whole-frame mode), one event issues all `cfg_bcnt` arrays of a frame on consecutive accepted handshakes. Array i is at frame start + i × array stride. The next frame starts at the current frame start plus the frame stride.
- R6: While `req_valid` is 1 and `req_ready` is 0, the request and its fields hold stable.
- R7: One cycle after the last array of an event is accepted, `inter_done` pulses if the transfer is not over. `final_done` pulses instead after the last array of the last frame, and `busy` falls in that same cycle. The two pulses never coincide.
- R8: An event that arrives while an event's arrays are still being issued is held, one deep, and served afterwards. Further events in that window are dropped. Events while idle are ignored.
- R9: Address arithmetic is 32-bit with 16-bit strides sign-extended, and it wraps modulo 2^32.
- R10: `cur_bcnt` gives the arrays left in the current frame, including the one being offered. `cur_ccnt` gives the frames left, including the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the parameter set (idle only) |
| cfg_frame_mode | input | 1 | 0 = one array per event, 1 = one frame per event |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays per frame |
| cfg_ccnt | input | 16 | Frames per transfer |
| cfg_bcnt_rld | input | 16 | Arrays per frame after the first (single-array mode) |
| cfg_src_bstride | input | 16 | Signed source array stride |
| cfg_dst_bstride | input | 16 | Signed destination array stride |
| cfg_src_cstride | input | 16 | Signed source frame stride |
| cfg_dst_cstride | input | 16 | Signed destination frame stride |
| evt | input | 1 | Sync event |
| req_valid | output | 1 | Array request offered |
| req_ready | input | 1 | Array request accepted |
| req_src | output | 32 | Array source address |
| req_dst | output | 32 | Array destination address |
| req_len | output | 16 | Array length in bytes |
| busy | output | 1 | A transfer is loaded |
| inter_done | output | 1 | Pulse: an event's work done, transfer continues |
| final_done | output | 1 | Pulse: transfer finished |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current destination address |
| cur_bcnt | output | 16 | Arrays left in current frame |
| cur_ccnt | output | 16 | Frames left |

## Verification
An event sampled at a clock edge shows as `req_valid` just after that edge. A request accepted at an edge shows its successor address, the completion pulse, the updated counts and any fall of `busy` just after that edge. A held event needs one extra idle cycle before its array is offered. The bench changes inputs and reads outputs only on the falling edge. It therefore looks at each result half a cycle after the rising edge that produces it. Where the design waits for a handshake, the bench counts exactly one such edge before it checks.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_frame_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [CW-1:0] cfg_bcnt_rld,
  input  logic [IW-1:0] cfg_src_bstride,
  input  logic [IW-1:0] cfg_dst_bstride,
  input  logic [IW-1:0] cfg_src_cstride,
  input  logic [IW-1:0] cfg_dst_cstride,
  input  logic          evt,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [CW-1:0] req_len,
  output logic          busy,
  output logic          inter_done,
  output logic          final_done,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_bcnt,
  output logic [CW-1:0] cur_ccnt
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE} state_t;

  state_t        st;
  logic          ab;
  logic [AW-1:0] src, dst, fsrc, fdst;
  logic [CW-1:0] alen, bcnt, bfull, brld, ccnt;
  logic [IW-1:0] sb, db, sc, dc;
  logic          evt_q, inter_q, final_q;

  wire [AW-1:0] sbx = {{(AW-IW){sb[IW-1]}}, sb};
  wire [AW-1:0] dbx = {{(AW-IW){db[IW-1]}}, db};
  wire [AW-1:0] scx = {{(AW-IW){sc[IW-1]}}, sc};
  wire [AW-1:0] dcx = {{(AW-IW){dc[IW-1]}}, dc};

  wire          last_arr = (bcnt == CW'(1));
  wire          last_frm = (ccnt == CW'(1));
  wire [AW-1:0] nxt_fsrc = (ab ? fsrc : src) + scx;
  wire [AW-1:0] nxt_fdst = (ab ? fdst : dst) + dcx;
  wire          cfg_ok   = (cfg_bcnt != '0) && (cfg_ccnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ab      <= 1'b0;
      src     <= '0;
      dst     <= '0;
      fsrc    <= '0;
      fdst    <= '0;
      alen    <= '0;
      bcnt    <= '0;
      bfull   <= '0;
      brld    <= '0;
      ccnt    <= '0;
      sb      <= '0;
      db      <= '0;
      sc      <= '0;
      dc      <= '0;
      evt_q   <= 1'b0;
      inter_q <= 1'b0;
      final_q <= 1'b0;
    end else begin
      inter_q <= 1'b0;
      final_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && cfg_ok) begin
            st    <= S_WAIT;
            ab    <= cfg_frame_mode;
            src   <= cfg_src;
            dst   <= cfg_dst;
            fsrc  <= cfg_src;
            fdst  <= cfg_dst;
            alen  <= cfg_acnt;
            bcnt  <= cfg_bcnt;
            bfull <= cfg_bcnt;
            brld  <= cfg_bcnt_rld;
            ccnt  <= cfg_ccnt;
            sb    <= cfg_src_bstride;
            db    <= cfg_dst_bstride;
            sc    <= cfg_src_cstride;
            dc    <= cfg_dst_cstride;
            evt_q <= 1'b0;
          end
        end
        S_WAIT: begin
          if (evt || evt_q) begin
            st    <= S_ISSUE;
            evt_q <= 1'b0;
          end
        end
        S_ISSUE: begin
          if (evt) evt_q <= 1'b1;
          if (req_ready) begin
            if (!last_arr) begin
              bcnt <= bcnt - CW'(1);
              src  <= src + sbx;
              dst  <= dst + dbx;
              if (!ab) begin
                st      <= S_WAIT;
                inter_q <= 1'b1;
              end
            end else if (!last_frm) begin
              ccnt    <= ccnt - CW'(1);
              bcnt    <= ab ? bfull : brld;
              src     <= nxt_fsrc;
              dst     <= nxt_fdst;
              fsrc    <= nxt_fsrc;
              fdst    <= nxt_fdst;
              st      <= S_WAIT;
              inter_q <= 1'b1;
            end else begin
              st      <= S_IDLE;
              final_q <= 1'b1;
              evt_q   <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_valid  = (st == S_ISSUE);
  assign req_src    = src;
  assign req_dst    = dst;
  assign req_len    = alen;
  assign busy       = (st != S_IDLE);
  assign inter_done = inter_q;
  assign final_done = final_q;
  assign cur_src    = src;
  assign cur_dst    = dst;
  assign cur_bcnt   = bcnt;
  assign cur_ccnt   = ccnt;

endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_src,
  input logic [AW-1:0] req_dst,
  input logic [CW-1:0] req_len,
  input logic          inter_done,
  input logic          final_done,
  input logic [CW-1:0] cur_ccnt
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R2
  frames_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_ccnt != '0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len)));

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inter_done && final_done));

  // R7
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inter_done || final_done) |-> $past(req_valid && req_ready));

  // R7
  final_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_done |-> (!busy && !req_valid));

endmodule

bind dma3d_seq dma3d_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_src    (req_src),
  .req_dst    (req_dst),
  .req_len    (req_len),
  .inter_done (inter_done),
  .final_done (final_done),
  .cur_ccnt   (cur_ccnt)
);

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_frame_mode = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_acnt = '0, cfg_bcnt = '0, cfg_ccnt = '0, cfg_bcnt_rld = '0;
  logic [15:0] cfg_src_bstride = '0, cfg_dst_bstride = '0;
  logic [15:0] cfg_src_cstride = '0, cfg_dst_cstride = '0;
  logic        evt = 1'b0;
  logic        req_ready = 1'b0;
  logic        req_valid, busy, inter_done, final_done;
  logic [31:0] req_src, req_dst, cur_src, cur_dst;
  logic [15:0] req_len, cur_bcnt, cur_ccnt;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dma3d_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_frame_mode(cfg_frame_mode),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt),
    .cfg_ccnt(cfg_ccnt), .cfg_bcnt_rld(cfg_bcnt_rld),
    .cfg_src_bstride(cfg_src_bstride), .cfg_dst_bstride(cfg_dst_bstride),
    .cfg_src_cstride(cfg_src_cstride), .cfg_dst_cstride(cfg_dst_cstride),
    .evt(evt), .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_dst(req_dst), .req_len(req_len), .busy(busy), .inter_done(inter_done),
    .final_done(final_done), .cur_src(cur_src), .cur_dst(cur_dst),
    .cur_bcnt(cur_bcnt), .cur_ccnt(cur_ccnt)
  );

  typedef struct packed {
    logic        ab;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [15:0] rld;
    logic [15:0] sb;
    logic [15:0] db;
    logic [15:0] sc;
    logic [15:0] dc;
    logic [15:0] exp_reqs;
    logic [31:0] exp_last_src;
  } case_t;

  localparam int NCASES = 4;
  localparam case_t CASES [NCASES] = '{
    '{1'b0, 32'h0000_0100, 32'h0000_0800, 16'd2, 16'd2, 16'd3, 16'd2,
      16'd2, 16'd2, 16'd2, 16'd2, 16'd6, 32'h0000_010A},
    '{1'b1, 32'h0000_0100, 32'h0000_0800, 16'd2, 16'd2, 16'd3, 16'd2,
      16'd2, 16'd2, 16'd4, 16'd4, 16'd6, 32'h0000_010A},
    '{1'b0, 32'h0000_1000, 32'h0000_2000, 16'd4, 16'd3, 16'd2, 16'd2,
      16'h0010, 16'd4, 16'hFFF8, 16'h0100, 16'd5, 32'h0000_1028},
    '{1'b1, 32'hFFFF_FFF8, 32'h0000_0010, 16'd4, 16'd2, 16'd2, 16'd1,
      16'd4, 16'hFFFC, 16'd8, 16'hFFE0, 16'd4, 32'h0000_0004}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_evt();
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic load(input case_t k);
    cfg_frame_mode  = k.ab;
    cfg_src         = k.src;
    cfg_dst         = k.dst;
    cfg_acnt        = k.a;
    cfg_bcnt        = k.b;
    cfg_ccnt        = k.c;
    cfg_bcnt_rld    = k.rld;
    cfg_src_bstride = k.sb;
    cfg_dst_bstride = k.db;
    cfg_src_cstride = k.sc;
    cfg_dst_cstride = k.dc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input case_t k);
    logic [31:0] s, d, fs, fd, last_s;
    int nreq;
    int nb;
    bit lastev, fin;
    load(k);
    chk(busy === 1'b1, "R2", "busy after start", {31'b0, busy}, 32'd1);
    chk(cur_src === k.src && cur_dst === k.dst, "R2", "loaded addr", cur_src, k.src);
    chk(cur_ccnt === k.c, "R10", "frames left at start", {16'b0, cur_ccnt}, {16'b0, k.c});
    s = k.src; d = k.dst; nreq = 0; last_s = '0;
    req_ready = 1'b1;
    for (int c = 0; c < int'(k.c); c++) begin
      nb = (c == 0 || k.ab) ? int'(k.b) : int'(k.rld);
      fs = s; fd = d;
      if (k.ab) pulse_evt();
      for (int b = 0; b < nb; b++) begin
        if (!k.ab) pulse_evt();
        chk(req_valid === 1'b1 && req_src === s && req_dst === d && req_len === k.a,
            k.ab ? "R5" : (c > 0 && b == 0 ? "R4" : "R3"), "request src", req_src, s);
        chk(req_dst === d, "R9", "request dst", req_dst, d);
        last_s = s;
        @(negedge clk);
        nreq++;
        lastev = k.ab ? (b == nb - 1) : 1'b1;
        fin = (c == int'(k.c) - 1) && (b == nb - 1);
        chk(inter_done === (lastev && !fin) && final_done === fin, "R7", "completion pulses",
            {30'b0, inter_done, final_done}, {30'b0, lastev && !fin, fin});
        if (b < nb - 1) begin
          s = s + {{16{k.sb[15]}}, k.sb};
          d = d + {{16{k.db[15]}}, k.db};
        end else if (k.ab) begin
          s = fs + {{16{k.sc[15]}}, k.sc};
          d = fd + {{16{k.dc[15]}}, k.dc};
        end else begin
          s = s + {{16{k.sc[15]}}, k.sc};
          d = d + {{16{k.dc[15]}}, k.dc};
        end
      end
    end
    chk(busy === 1'b0, "R7", "busy low after final", {31'b0, busy}, 32'd0);
    chk(nreq == int'(k.exp_reqs) && last_s === k.exp_last_src, "R9", "request count / last src",
        last_s, k.exp_last_src);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && req_valid === 1'b0 && inter_done === 1'b0 && final_done === 1'b0,
        "R1", "reset outputs", {28'b0, busy, req_valid, inter_done, final_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: events while idle are ignored
    pulse_evt();
    repeat (2) begin
      chk(req_valid === 1'b0 && busy === 1'b0, "R8", "idle event ignored", {31'b0, req_valid}, 32'd0);
      @(negedge clk);
    end

    for (int i = 0; i < NCASES; i++) begin
      run_case(CASES[i]);
      @(negedge clk);
    end

    // R2: zero frame count start ignored
    load('{1'b0, 32'h55, 32'h66, 16'd1, 16'd1, 16'd0, 16'd1, 16'd1, 16'd1, 16'd1, 16'd1, 16'd0, 32'd0});
    chk(busy === 1'b0, "R2", "zero count start", {31'b0, busy}, 32'd0);
    pulse_evt();
    chk(req_valid === 1'b0, "R2", "no request after rejected start", {31'b0, req_valid}, 32'd0);

    // R6 / R8: backpressure and one-deep event queue
    req_ready = 1'b0;
    load('{1'b0, 32'h40, 32'h80, 16'd1, 16'd4, 16'd1, 16'd4, 16'd1, 16'd1, 16'd1, 16'd1, 16'd0, 32'd0});
    pulse_evt();
    chk(req_valid === 1'b1 && req_src === 32'h40, "R3", "first array", req_src, 32'h40);
    evt = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b1 && req_src === 32'h40 && req_dst === 32'h80, "R6", "held request", req_src, 32'h40);
    @(negedge clk);
    evt = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0 && inter_done === 1'b1 && cur_src === 32'h41, "R7", "accepted array",
        cur_src, 32'h41);
    @(negedge clk);
    chk(req_valid === 1'b1 && req_src === 32'h41, "R8", "queued event served", req_src, 32'h41);
    @(negedge clk);
    chk(inter_done === 1'b1, "R7", "second inter pulse", {31'b0, inter_done}, 32'd1);
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0, "R8", "extra event dropped", {31'b0, req_valid}, 32'd0);
    chk(cur_bcnt === 16'd2, "R10", "arrays left", {16'b0, cur_bcnt}, 32'd2);

    // R2: start while busy ignored
    cfg_src = 32'h999;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && cur_src === 32'h42, "R2", "start while busy", cur_src, 32'h42);

    pulse_evt();
    chk(req_valid === 1'b1 && req_src === 32'h42, "R3", "third array", req_src, 32'h42);
    @(negedge clk);
    pulse_evt();
    chk(req_src === 32'h43, "R3", "fourth array", req_src, 32'h43);
    @(negedge clk);
    chk(final_done === 1'b1 && busy === 1'b0, "R7", "final pulse", {30'b0, final_done, busy}, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule